// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Unit

This block gathers the interrupt requests of two IDE channels. Each channel has a drive request and a bus-master (DMA completion) request. A rising edge on a request sets a status bit. The bit stays set while the request stays high and until the host acknowledges that channel. Each channel has a mask bit that silences only its interrupt output. The status bits themselves are not affected by the mask. Each channel's output has a selectable polarity.

The host sees two byte registers on a small synchronous register bus with combinational read data:

- **Offset 2, read:** the channel-0 status.
- **Offset 2, write:** a separate write-only mode byte, which is guarded by a key bit.
- **Offset 3:** the two mask bits, the channel-1 status bits and a strap that reports whether a legacy header is present.

The mode byte drives two outputs that the rest of the controller uses: legacy-compatible addressing and test mode.

Top module: `ide_irq_status`

## Requirements
- R1: While `rst` is high and after it falls, every status bit, both mask bits and both mode outputs are 0, and each `irq_out[c]` sits at its inactive level, which equals `irq_pol_low[c]`.
- R2: On a clock edge where a request (`drv_req[c]` or `bm_req[c]`) is high and was low at the previous edge, the matching status bit is 1 after that edge. A request held high does not set the bit again.
- R3: A status bit clears at an edge where its request is low. It also clears at an edge where `irq_ack[c]` is high, and an acknowledge clears both status bits of channel c. A new rising edge in the same cycle as an acknowledge wins, so the bit stays set.
- R4: A read at offset 2 returns bit 1 = channel-0 bus-master status and bit 0 = channel-0 drive status. Bits 7..2 read 0.
- R5: A read at offset 3 returns the following, with all other bits reading 0:
  - bit 4 = `legacy_hdr_strap`
  - bit 3 = channel-1 bus-master status
  - bit 2 = channel-1 drive status
  - bits 1..0 = mask of channel 1 and channel 0

  Reads at offsets 0 and 1 return 0.
- R6: A write at offset 3 loads bits 1..0 into the channel-1 and channel-0 mask bits. The write has no effect on the status bits.
- R7: A write at offset 2 updates the mode byte only when data bit 7 is 1. In that case bit 1 drives `mode_legacy` and bit 0 drives `mode_test`. A write with bit 7 at 0 is ignored. Writes at offset 2 never change the status read back at offset 2.
- R8: `irq_out[c]` is active exactly when channel c has at least one status bit set and its mask bit is 0. Masking leaves the status bits readable and unchanged.
- R9: With `irq_pol_low[c]` = 0 the active level of `irq_out[c]` is 1 (active high). With `irq_pol_low[c]` = 1 the active level is 0 (active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset |
| reg_wr | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| drv_req | input | 2 | Drive interrupt request per channel |
| bm_req | input | 2 | Bus-master interrupt request per channel |
| irq_ack | input | 2 | Host acknowledge per channel; clears that channel's status |
| irq_pol_low | input | 2 | Output polarity per channel (1 = active low) |
| legacy_hdr_strap | input | 1 | Strap: legacy header present |
| irq_out | output | 2 | Interrupt output per channel |
| mode_legacy | output | 1 | Legacy-compatible mode selected |
| mode_test | output | 1 | Test mode selected |

## Verification
Timing through the block:

- **One edge:** each request, acknowledge or register write takes effect at the first clock edge that samples it. The status bits, mask bits and mode outputs hold their new values immediately after that edge.
- **No added delay:** `reg_rdata` and `irq_out` are combinational from those registers and from `reg_addr` and `irq_pol_low`, so they add no cycle.

How the bench keeps to this:

- Inputs are driven on the falling edge.
- After the following rising edge, results are sampled one nanosecond later.
- Read data is compared one nanosecond after the address changes.
- A polarity change is checked without waiting for a clock.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int NCH    = 2;

    localparam logic [ADDR_W-1:0] OFS_CH0   = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 2'd3;
    localparam int                KEY_BIT   = 7;

    typedef struct packed {
        logic bm;
        logic drv;
    } chan_st_t;

    typedef struct packed {
        logic legacy;
        logic test;
    } mode_t;

    function automatic logic [DATA_W-1:0] read_mux(
        input logic [ADDR_W-1:0] addr,
        input chan_st_t          st0,
        input chan_st_t          st1,
        input logic [NCH-1:0]    mask,
        input logic              strap
    );
        logic [DATA_W-1:0] d;
        d = '0;
        case (addr)
            OFS_CH0:  d[1:0] = st0;
            OFS_MASK: begin
                d[4]   = strap;
                d[3:2] = st1;
                d[1:0] = mask;
            end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ide_irq_chan.sv
module ide_irq_chan
    import ide_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     drv_req,
    input  logic     bm_req,
    input  logic     ack,
    input  logic     mask,
    input  logic     pol_low,
    output chan_st_t st,
    output logic     irq
);

    chan_st_t req_q;
    chan_st_t req_now;
    chan_st_t st_nxt;

    assign req_now = '{bm: bm_req, drv: drv_req};

    // Per source: a fresh rising edge sets; a low request or an ack clears.
    always_comb begin
        st_nxt = st;
        if (req_now.drv && !req_q.drv)       st_nxt.drv = 1'b1;
        else if (!req_now.drv || ack)        st_nxt.drv = 1'b0;
        if (req_now.bm && !req_q.bm)         st_nxt.bm  = 1'b1;
        else if (!req_now.bm || ack)         st_nxt.bm  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            st    <= '0;
        end else begin
            req_q <= req_now;
            st    <= st_nxt;
        end
    end

    assign irq = ((st.drv | st.bm) & ~mask) ^ pol_low;

endmodule

// File: rtl/ide_irq_regs.sv
module ide_irq_regs
    import ide_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCH-1:0]    mask,
    output mode_t             mode
);

    logic unused_wbits;
    assign unused_wbits = ^wdata[6:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
            mode <= '0;
        end else if (wr) begin
            if (addr == OFS_MASK)
                mask <= wdata[NCH-1:0];
            if (addr == OFS_CH0 && wdata[KEY_BIT])
                mode <= '{legacy: wdata[1], test: wdata[0]};
        end
    end

endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status
    import ide_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    drv_req,
    input  logic [NCH-1:0]    bm_req,
    input  logic [NCH-1:0]    irq_ack,
    input  logic [NCH-1:0]    irq_pol_low,
    input  logic              legacy_hdr_strap,
    output logic [NCH-1:0]    irq_out,
    output logic              mode_legacy,
    output logic              mode_test
);

    chan_st_t         st [NCH];
    logic [NCH-1:0]   mask;
    logic [NCH-1:0]   drv_st;
    logic [NCH-1:0]   bm_st;
    mode_t            mode;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ide_irq_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .drv_req (drv_req[c]),
            .bm_req  (bm_req[c]),
            .ack     (irq_ack[c]),
            .mask    (mask[c]),
            .pol_low (irq_pol_low[c]),
            .st      (st[c]),
            .irq     (irq_out[c])
        );
        assign drv_st[c] = st[c].drv;
        assign bm_st[c]  = st[c].bm;
    end

    ide_irq_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .mask  (mask),
        .mode  (mode)
    );

    assign reg_rdata   = read_mux(reg_addr, st[0], st[1], mask, legacy_hdr_strap);
    assign mode_legacy = mode.legacy;
    assign mode_test   = mode.test;

endmodule

// File: rtl/ide_irq_status_chk.sv
module ide_irq_status_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [1:0] drv_req,
    input logic [1:0] bm_req,
    input logic [1:0] irq_pol_low,
    input logic [1:0] irq_out,
    input logic [1:0] drv_st,
    input logic [1:0] bm_st,
    input logic [1:0] mask,
    input logic       mode_legacy,
    input logic       mode_test
);

    for (genvar c = 0; c < 2; c++) begin : g_c
        // R2
        a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
            $rose(drv_req[c]) |=> drv_st[c]);
        // R3
        a_r3_low_clears: assert property (@(posedge clk) disable iff (rst)
            !bm_req[c] |=> !bm_st[c]);
        // R8
        a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
            mask[c] |-> irq_out[c] == irq_pol_low[c]);
    end

    // R6
    a_r6_mask_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3) |=> mask == $past(reg_wdata[1:0]));

    // R7
    a_r7_key_guard: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && !reg_wdata[7])
        |=> $stable({mode_legacy, mode_test}));

endmodule

bind ide_irq_status ide_irq_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .drv_req     (drv_req),
    .bm_req      (bm_req),
    .irq_pol_low (irq_pol_low),
    .irq_out     (irq_out),
    .drv_st      (drv_st),
    .bm_st       (bm_st),
    .mask        (mask),
    .mode_legacy (mode_legacy),
    .mode_test   (mode_test)
);

// File: tb/ide_irq_status_test.sv
`timescale 1ns/100ps
module ide_irq_status_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] drv_req = '0;
    logic [1:0] bm_req = '0;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq_pol_low = '0;
    logic       legacy_hdr_strap = 1'b0;
    logic [1:0] irq_out;
    logic       mode_legacy;
    logic       mode_test;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ide_irq_status uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_req(drv_req),
        .bm_req(bm_req), .irq_ack(irq_ack), .irq_pol_low(irq_pol_low),
        .legacy_hdr_strap(legacy_hdr_strap), .irq_out(irq_out),
        .mode_legacy(mode_legacy), .mode_test(mode_test)
    );

    // {drv_req, bm_req, irq_ack, exp ch0 {bm,drv}, exp ch1 {bm,drv}, exp irq}
    localparam int NV = 9;
    localparam logic [11:0] VEC [NV] = '{
        12'b01_00_00_01_00_01,  // R2 drive ch0 rises
        12'b01_10_00_01_10_11,  // R2 bus-master ch1 rises
        12'b01_10_01_00_10_10,  // R3 ack ch0, held request no re-set
        12'b01_10_00_00_10_10,  // R2 held high stays clear
        12'b00_00_00_00_00_00,  // R3 requests low clear
        12'b11_11_11_11_11_11,  // R3 rise beats ack
        12'b10_11_00_10_11_11,  // R3 ch0 drive low clears
        12'b10_01_00_10_01_11,  // R3 ch1 bus-master low clears
        12'b00_00_00_00_00_00   // R3 all clear
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 irq", {6'b0, irq_out}, 8'h00);
        rd(2'd2, "R1 st0", 8'h00);
        rd(2'd3, "R1 mask", 8'h00);
        chk("R1 mode", {6'b0, mode_legacy, mode_test}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // vector walk: R2 R3 R4 R5 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {drv_req, bm_req, irq_ack} = VEC[i][11:6];
            step();
            irq_ack = '0;
            rd(2'd2, $sformatf("R4 vec%0d", i), {6'b0, VEC[i][5:4]});
            rd(2'd3, $sformatf("R5 vec%0d", i), {4'b0, VEC[i][3:2], 2'b00});
            chk($sformatf("R8 vec%0d", i), {6'b0, irq_out}, {6'b0, VEC[i][1:0]});
        end

        // R5 strap and unused offsets
        legacy_hdr_strap = 1'b1;
        rd(2'd3, "R5 strap", 8'h10);
        rd(2'd0, "R5 ofs0", 8'h00);
        rd(2'd1, "R5 ofs1", 8'h00);

        // R6 mask write ignores status bits
        @(negedge clk);
        drv_req[1] = 1'b1;
        step();
        rd(2'd3, "R2 ch1 drv", 8'h14);
        wr(2'd3, 8'h0B);
        rd(2'd3, "R6 mask load", 8'h17);
        // R8 masked: status kept, output quiet
        chk("R8 masked irq", {6'b0, irq_out}, 8'h00);
        wr(2'd3, 8'h00);
        chk("R8 unmasked irq", {6'b0, irq_out}, 8'h02);

        // R9 polarity
        irq_pol_low = 2'b11;
        #1;
        chk("R9 active low", {6'b0, irq_out}, 8'h01);
        irq_pol_low = 2'b00;
        #1;
        chk("R9 active high", {6'b0, irq_out}, 8'h02);

        // R7 mode byte with key
        wr(2'd2, 8'h03);
        chk("R7 no key", {6'b0, mode_legacy, mode_test}, 8'h00);
        wr(2'd2, 8'h83);
        chk("R7 key set", {6'b0, mode_legacy, mode_test}, 8'h03);
        rd(2'd2, "R7 status read", 8'h00);
        wr(2'd2, 8'h82);
        chk("R7 legacy only", {6'b0, mode_legacy, mode_test}, 8'h02);

        // R1 mid-run reset
        @(negedge clk);
        wr(2'd3, 8'h03);
        @(negedge clk);
        rst = 1'b1;
        step();
        rd(2'd3, "R1 mid reset", 8'h10);
        chk("R1 mid mode", {6'b0, mode_legacy, mode_test}, 8'h00);
        chk("R1 mid irq", {6'b0, irq_out}, 8'h00);

        done = 1;
        finish_run();
    end

endmodule